// File: doc/BRIEF.md
# Hypervisor Trap Delegation Router

This combinational block decides which privilege level takes a trap in a core that supports virtualisation. It also computes the address where that level's handler starts. It receives four inputs:

- the current privilege;
- a possible synchronous exception;
- a 64-bit vector of interrupts that are already pending, enabled and filtered;
- the delegation, virtual-interrupt-enable and trap-vector registers of the machine, supervisor and virtual-supervisor levels.

It drives a target level, the cause value to be written, an 8-bit interrupt number and the handler PC. All of these are valid in the same cycle as the inputs.

Interrupts are split into three take-sets: machine, supervisor and virtual-supervisor. Each set is formed by masking with the delegation and virtual-enable registers. A set is only eligible when the hart currently runs below that set's level. Exceptions follow the exception delegation registers. Delegation to the virtual-supervisor level requires that the exception was raised in a virtualised mode. The handler address uses the vector mode of the chosen level's own register.

The block has no states or transitions. It holds no sequential logic, and its single decision is a fixed-priority selection.

Top module: `trap_route`

## Requirements
- R1: An interrupt that stays at machine level is taken in M only if its number is 1 to 13. A number of 14 or more, or number 0, that is not delegated further is dropped and causes no trap.
- R2: The supervisor set is (pend AND mideleg) OR (pend AND NOT mideleg AND mvien). Its interrupts go to HS (tgt_mode=1) and are taken only when cur_priv is not M (cur_priv[1:0]=3 means M).
- R3: The virtual set is (S AND hideleg) OR (S AND NOT hideleg AND hvien), where S is the supervisor set. Its interrupts go to VS (tgt_mode=2) and are taken only when cur_priv[2]=1 (VS=3'b101, VU=3'b100).
- R4: The M set beats the HS set, which beats the VS set. Within the winning set, the lowest-numbered bit is taken.
- R5: When an interrupt and an exception arrive together, the interrupt is reported.
- R6: An exception goes to M when cur_priv is M or medeleg[cause] is 0. Otherwise it goes to HS, unless cur_priv[2]=1 and hedeleg[cause]=1, in which case it goes to VS.
- R7: Interrupts 2, 6 and 10 are reported as 1, 5 and 9 only when the target is VS. At M or HS they keep their own number.
- R8: The trap-vector register of the target level is used. Its bits [1:0] are the mode, and mode 1 means vectored. The base is the register with bits [1:0] cleared. For an interrupt in vectored mode, the PC is base + 4 × reported code.
- R9: An exception, and any trap in direct mode, enters at the base.
- R10: cause_out[63] is 1 for interrupts and 0 for exceptions, and cause_out[5:0] holds the code. irq_num is the 8-bit reported code for an interrupt and 0 otherwise.
- R11: With no trap, trap_valid is 0 and cause_out, irq_num and handler_pc are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_priv | input | 3 | Current privilege {virt, level} |
| exc_valid | input | 1 | Exception present |
| exc_cause | input | 6 | Exception cause code |
| irq_pend | input | 64 | Pending-and-enabled interrupts |
| mideleg | input | 64 | Machine interrupt delegation |
| mvien | input | 64 | Machine virtual-interrupt enable |
| hideleg | input | 64 | Hypervisor interrupt delegation |
| hvien | input | 64 | Hypervisor virtual-interrupt enable |
| medeleg | input | 64 | Machine exception delegation |
| hedeleg | input | 64 | Hypervisor exception delegation |
| mtvec | input | 64 | Machine trap vector |
| stvec | input | 64 | Supervisor trap vector |
| vstvec | input | 64 | Virtual-supervisor trap vector |
| trap_valid | output | 1 | A trap is taken |
| tgt_mode | output | 2 | 0=M, 1=HS, 2=VS |
| cause_out | output | 64 | Reported cause |
| irq_num | output | 8 | Interrupt number |
| handler_pc | output | 64 | Handler entry address |

## Verification
The block holds no state, so a wrong internal decision shows on the ports in the same evaluation. It appears either as a wrong tgt_mode, or as a handler_pc offset that does not match the reported code. A mis-masked take-set shows up when a trap that should be dropped appears, or when a lower-priority number wins. A wrong remap shows in irq_num and in the vectored PC together.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
    typedef enum logic [1:0] {
        TGT_M  = 2'd0,
        TGT_HS = 2'd1,
        TGT_VS = 2'd2
    } tgt_e;

    localparam logic [1:0] TVEC_VECTORED = 2'd1;
endpackage

// File: rtl/trap_irq_levels.sv
module trap_irq_levels #(
    parameter int NUM_IRQ = 64,
    parameter int M_HI    = 13
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] mideleg,
    input  logic [NUM_IRQ-1:0] mvien,
    input  logic [NUM_IRQ-1:0] hideleg,
    input  logic [NUM_IRQ-1:0] hvien,
    output logic [NUM_IRQ-1:0] m_take,
    output logic [NUM_IRQ-1:0] hs_take,
    output logic [NUM_IRQ-1:0] vs_take
);
    logic [NUM_IRQ-1:0] m_allow;
    logic [NUM_IRQ-1:0] s_set;
    logic [NUM_IRQ-1:0] v_set;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_allow
        if (g >= 1 && g <= M_HI) begin : g_on
            assign m_allow[g] = 1'b1;
        end else begin : g_off
            assign m_allow[g] = 1'b0;
        end
    end

    assign s_set   = (pend & mideleg) | (pend & ~mideleg & mvien);
    assign v_set   = (s_set & hideleg) | (s_set & ~hideleg & hvien);
    assign m_take  = pend & ~s_set & m_allow;
    assign hs_take = s_set & ~v_set;
    assign vs_take = v_set;

    always_comb begin
        p_sets_disjoint_r4: assert ((m_take & hs_take) == '0 && (hs_take & vs_take) == '0)
            else $error("take sets overlap");
    end
endmodule

// File: rtl/trap_lowest_pick.sv
module trap_lowest_pick #(
    parameter int N = 64,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc
    import trap_route_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int CW   = 6
) (
    input  tgt_e            tgt,
    input  logic            is_irq,
    input  logic [CW-1:0]   code,
    input  logic [XLEN-1:0] mtvec,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] vstvec,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] tvec;
    logic [XLEN-1:0] base;

    always_comb begin
        unique case (tgt)
            TGT_HS:  tvec = stvec;
            TGT_VS:  tvec = vstvec;
            default: tvec = mtvec;
        endcase
        base = {tvec[XLEN-1:2], 2'b00};
        if (is_irq && tvec[1:0] == TVEC_VECTORED) begin
            pc = base + {{(XLEN-CW-2){1'b0}}, code, 2'b00};
        end else begin
            pc = base;
        end
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_route_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int CW     = 6,
    parameter int NUM_W  = 8,
    parameter int M_HI   = 13
) (
    input  logic [2:0]       cur_priv,
    input  logic             exc_valid,
    input  logic [CW-1:0]    exc_cause,
    input  logic [XLEN-1:0]  irq_pend,
    input  logic [XLEN-1:0]  mideleg,
    input  logic [XLEN-1:0]  mvien,
    input  logic [XLEN-1:0]  hideleg,
    input  logic [XLEN-1:0]  hvien,
    input  logic [XLEN-1:0]  medeleg,
    input  logic [XLEN-1:0]  hedeleg,
    input  logic [XLEN-1:0]  mtvec,
    input  logic [XLEN-1:0]  stvec,
    input  logic [XLEN-1:0]  vstvec,
    output logic             trap_valid,
    output logic [1:0]       tgt_mode,
    output logic [XLEN-1:0]  cause_out,
    output logic [NUM_W-1:0] irq_num,
    output logic [XLEN-1:0]  handler_pc
);
    localparam int NLVL = 3;

    logic [XLEN-1:0] take_set [NLVL];
    logic            lvl_found [NLVL];
    logic [CW-1:0]   lvl_idx [NLVL];

    logic in_m, in_virt;
    logic irq_hit;
    tgt_e tgt;
    logic [CW-1:0] raw_code, code;
    logic [XLEN-1:0] pc_calc;
    logic deleg_hs, deleg_vs;

    trap_irq_levels #(.NUM_IRQ(XLEN), .M_HI(M_HI)) u_levels (
        .pend    (irq_pend),
        .mideleg (mideleg),
        .mvien   (mvien),
        .hideleg (hideleg),
        .hvien   (hvien),
        .m_take  (take_set[0]),
        .hs_take (take_set[1]),
        .vs_take (take_set[2])
    );

    for (genvar l = 0; l < NLVL; l++) begin : g_pick
        trap_lowest_pick #(.N(XLEN), .W(CW)) u_pick (
            .vec   (take_set[l]),
            .found (lvl_found[l]),
            .idx   (lvl_idx[l])
        );
    end

    assign in_m    = (cur_priv[1:0] == 2'b11);
    assign in_virt = cur_priv[2];

    always_comb begin
        deleg_hs = !in_m && medeleg[exc_cause];
        deleg_vs = deleg_hs && in_virt && hedeleg[exc_cause];
        irq_hit  = 1'b0;
        tgt      = TGT_M;
        raw_code = exc_cause;
        if (lvl_found[0]) begin
            irq_hit  = 1'b1;
            tgt      = TGT_M;
            raw_code = lvl_idx[0];
        end else if (lvl_found[1] && !in_m) begin
            irq_hit  = 1'b1;
            tgt      = TGT_HS;
            raw_code = lvl_idx[1];
        end else if (lvl_found[2] && in_virt) begin
            irq_hit  = 1'b1;
            tgt      = TGT_VS;
            raw_code = lvl_idx[2];
        end else if (deleg_vs) begin
            tgt = TGT_VS;
        end else if (deleg_hs) begin
            tgt = TGT_HS;
        end
        code = raw_code;
        if (irq_hit && tgt == TGT_VS &&
            (raw_code == CW'(2) || raw_code == CW'(6) || raw_code == CW'(10))) begin
            code = raw_code - CW'(1);
        end
    end

    trap_entry_calc #(.XLEN(XLEN), .CW(CW)) u_entry (
        .tgt    (tgt),
        .is_irq (irq_hit),
        .code   (code),
        .mtvec  (mtvec),
        .stvec  (stvec),
        .vstvec (vstvec),
        .pc     (pc_calc)
    );

    assign trap_valid = irq_hit | exc_valid;
    assign tgt_mode   = trap_valid ? tgt : TGT_M;
    assign cause_out  = trap_valid ? {irq_hit, {(XLEN-CW-1){1'b0}}, code} : '0;
    assign irq_num    = irq_hit ? NUM_W'(code) : '0;
    assign handler_pc = trap_valid ? pc_calc : '0;

    always_comb begin
        p_vs_needs_virt_r3: assert (!(trap_valid && tgt_mode == TGT_VS) || cur_priv[2])
            else $error("VS target from non-virtual mode");
        p_m_irq_range_r1: assert (!(irq_hit && tgt_mode == TGT_M) ||
                                  (irq_num >= 1 && irq_num <= NUM_W'(M_HI)))
            else $error("M interrupt number out of range");
        p_pc_aligned_r8: assert (handler_pc[1:0] == 2'b00)
            else $error("handler pc misaligned");
        p_idle_quiet_r11: assert (trap_valid || (handler_pc == '0 && irq_num == '0 && cause_out == '0))
            else $error("outputs active without trap");
        p_hs_not_from_m_r2: assert (!(irq_hit && tgt_mode == TGT_HS) || !in_m)
            else $error("HS interrupt taken in M");
    end
endmodule

// File: tb/sim_trap_route.sv
module sim_trap_route;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [2:0]  cur_priv;
    logic        exc_valid;
    logic [5:0]  exc_cause;
    logic [63:0] irq_pend, mideleg, mvien, hideleg, hvien, medeleg, hedeleg;
    logic [63:0] mtvec, stvec, vstvec;
    logic        trap_valid;
    logic [1:0]  tgt_mode;
    logic [63:0] cause_out;
    logic [7:0]  irq_num;
    logic [63:0] handler_pc;

    trap_route u0 (.*);

    typedef struct packed {
        logic [2:0]  cur;
        logic        ev;
        logic [5:0]  ec;
        logic [63:0] irq, mid, mvi, hid, hvi, med, hed;
        logic        xv;
        logic [1:0]  xt;
        logic        xi;
        logic [5:0]  xc;
        logic [63:0] xpc;
        logic [7:0]  req;
    } vec_t;

    localparam logic [2:0] U = 3'b000, HS = 3'b001, M = 3'b011, VU = 3'b100, VS = 3'b101;
    localparam logic [63:0] B2 = 64'd1 << 2, B3 = 64'd1 << 3, B5 = 64'd1 << 5, B6 = 64'd1 << 6;
    localparam logic [63:0] B7 = 64'd1 << 7, B8 = 64'd1 << 8, B9 = 64'd1 << 9, B10 = 64'd1 << 10;
    localparam logic [63:0] B20 = 64'd1 << 20, Z = 64'd0;
    localparam int NV = 19;

    localparam vec_t TBL [NV] = '{
        '{U, 1'b0, 6'd0, B7, Z, Z, Z, Z, Z, Z, 1'b1, 2'd0, 1'b1, 6'd7, 64'h8000001C, 8'd1},   // R1
        '{U, 1'b0, 6'd0, B5, B5, Z, Z, Z, Z, Z, 1'b1, 2'd1, 1'b1, 6'd5, 64'h40000000, 8'd2},  // R2
        '{VS, 1'b0, 6'd0, B6, B6, Z, B6, Z, Z, Z, 1'b1, 2'd2, 1'b1, 6'd5, 64'h20000014, 8'd7}, // R7 remap
        '{HS, 1'b0, 6'd0, B6, B6, Z, B6, Z, Z, Z, 1'b0, 2'd0, 1'b0, 6'd0, Z, 8'd3},          // R3 not in HS
        '{U, 1'b0, 6'd0, B10, B10, Z, Z, Z, Z, Z, 1'b1, 2'd1, 1'b1, 6'd10, 64'h40000000, 8'd7}, // R7 keep
        '{U, 1'b0, 6'd0, B10, Z, Z, Z, Z, Z, Z, 1'b1, 2'd0, 1'b1, 6'd10, 64'h80000028, 8'd1}, // R1
        '{U, 1'b0, 6'd0, B20, Z, B20, Z, Z, Z, Z, 1'b1, 2'd1, 1'b1, 6'd20, 64'h40000000, 8'd2}, // R2 mvien
        '{U, 1'b0, 6'd0, B20, Z, Z, Z, Z, Z, Z, 1'b0, 2'd0, 1'b0, 6'd0, Z, 8'd1},            // R1 drop
        '{VU, 1'b0, 6'd0, B20, Z, B20, Z, B20, Z, Z, 1'b1, 2'd2, 1'b1, 6'd20, 64'h20000050, 8'd3}, // R3 hvien
        '{U, 1'b0, 6'd0, B3 | B9, B9, Z, Z, Z, Z, Z, 1'b1, 2'd0, 1'b1, 6'd3, 64'h8000000C, 8'd4}, // R4
        '{U, 1'b0, 6'd0, B5 | B9, B5 | B9, Z, Z, Z, Z, Z, 1'b1, 2'd1, 1'b1, 6'd5, 64'h40000000, 8'd4}, // R4
        '{U, 1'b1, 6'd8, Z, Z, Z, Z, Z, B8, Z, 1'b1, 2'd1, 1'b0, 6'd8, 64'h40000000, 8'd6},  // R6
        '{VU, 1'b1, 6'd8, Z, Z, Z, Z, Z, B8, B8, 1'b1, 2'd2, 1'b0, 6'd8, 64'h20000000, 8'd9}, // R9
        '{HS, 1'b1, 6'd8, Z, Z, Z, Z, Z, B8, B8, 1'b1, 2'd1, 1'b0, 6'd8, 64'h40000000, 8'd6}, // R6
        '{M, 1'b1, 6'd8, Z, Z, Z, Z, Z, B8, Z, 1'b1, 2'd0, 1'b0, 6'd8, 64'h80000000, 8'd6},  // R6
        '{U, 1'b1, 6'd2, B7, Z, Z, Z, Z, Z, Z, 1'b1, 2'd0, 1'b1, 6'd7, 64'h8000001C, 8'd5},  // R5
        '{M, 1'b0, 6'd0, B5, B5, Z, Z, Z, Z, Z, 1'b0, 2'd0, 1'b0, 6'd0, Z, 8'd2},            // R2 not in M
        '{VS, 1'b0, 6'd0, B6, B6, Z, Z, Z, Z, Z, 1'b1, 2'd1, 1'b1, 6'd6, 64'h40000000, 8'd7}, // R7 keep
        '{VS, 1'b0, 6'd0, B5 | B6, B5 | B6, Z, B6, Z, Z, Z, 1'b1, 2'd1, 1'b1, 6'd5, 64'h40000000, 8'd4} // R4
    };

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        @(posedge clk);
        cur_priv = v.cur; exc_valid = v.ev; exc_cause = v.ec;
        irq_pend = v.irq; mideleg = v.mid; mvien = v.mvi;
        hideleg = v.hid; hvien = v.hvi; medeleg = v.med; hedeleg = v.hed;
        @(negedge clk);
    endtask

    task automatic check_row(input vec_t v, input string rq);
        chk(rq, "trap_valid", 64'(trap_valid), 64'(v.xv));
        chk(rq, "tgt_mode", 64'(tgt_mode), 64'(v.xv ? v.xt : 2'd0));
        chk(rq, "cause_out", cause_out, v.xv ? {v.xi, 57'd0, v.xc} : 64'd0);   // R10
        chk(rq, "irq_num", 64'(irq_num), v.xi ? 64'(v.xc) : 64'd0);             // R10
        chk(rq, "handler_pc", handler_pc, v.xpc);                              // R8
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        vec_t d;
        cur_priv = U; exc_valid = 1'b0; exc_cause = '0;
        irq_pend = '0; mideleg = '0; mvien = '0; hideleg = '0; hvien = '0;
        medeleg = '0; hedeleg = '0;
        mtvec = 64'h80000001; stvec = 64'h40000000; vstvec = 64'h20000001;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 quiet with nothing pending
        chk("R11", "idle valid", 64'(trap_valid), 64'd0);
        chk("R11", "idle pc", handler_pc, 64'd0);
        chk("R11", "idle cause", cause_out, 64'd0);

        for (int i = 0; i < NV; i++) begin
            load(TBL[i]);
            check_row(TBL[i], $sformatf("R%0d", TBL[i].req));
        end

        // R8 supervisor vectored through its own mode field
        stvec = 64'h40000001;
        load(TBL[1]);
        chk("R8", "stvec vectored pc", handler_pc, 64'h40000014);
        stvec = 64'h40000000;
        // R8 machine direct mode
        mtvec = 64'h80000000;
        load(TBL[0]);
        chk("R8", "mtvec direct pc", handler_pc, 64'h80000000);
        // R8 base bits cleared with a non-vectored mode value
        mtvec = 64'h80000003;
        load(TBL[0]);
        chk("R8", "mtvec mode3 pc", handler_pc, 64'h80000000);
        mtvec = 64'h80000001;
        // R1 interrupt 0 never taken in M
        d = TBL[7];
        d.irq = 64'd1;
        load(d);
        chk("R1", "irq0 dropped", 64'(trap_valid), 64'd0);
        // R1 interrupt 13 is the top of the M range
        d.irq = 64'd1 << 13;
        load(d);
        chk("R1", "irq13 taken", 64'(irq_num), 64'd13);
        chk("R1", "irq13 pc", handler_pc, 64'h80000034);
        // R7 interrupt 2 remap in VS
        d = TBL[2];
        d.irq = B2; d.mid = B2; d.hid = B2;
        load(d);
        chk("R7", "vssi remap", 64'(irq_num), 64'd1);
        chk("R7", "vssi pc", handler_pc, 64'h20000004);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule